// File: doc/BRIEF.md
# Move-Eliminating Register Renamer

This block translates logical register names into physical register names for one instruction per cycle. Stack-slot references arrive as logical registers. The block gives every fresh result its own physical register, and this removes false write-after-read and write-after-write hazards between slots. Each request carries one source, one destination, a flag that says whether the destination is written, and a flag that marks a pure data copy.

A copy costs no physical register. The destination's map entry is simply pointed at the physical register that already holds the source value, and the instruction is flagged as squashed so that later stages drop it. As a result, one physical register can stand behind several logical names at once. Every physical register therefore keeps a reference count. The count covers each logical name that maps to the register, plus each overwritten mapping that the pipeline has not yet handed back through the release port. A register re-enters the free pool only when its count falls to zero.

The surrounding pipeline does two things with the release port. It reads `prev_ptag` for every accepted destination write. Once the overwriting instruction can no longer be undone, it returns that tag on the release port. Branch recovery and checkpoints are not part of the block.

Top module: `mv_renamer`

## Requirements
- R1: After reset, logical register i maps to physical register i for i in 0..15, and physical registers 16..31 are free. `ready` is high, and the first allocation returns physical register 16.
- R2: Whenever `req_valid` is high, `src_ptag` shows the current mapping of `req_src` in the same cycle. The value is taken before any update made by that request.
- R3: A request with `req_valid=1`, `req_is_move=0` and `req_has_dst=1` takes the lowest-numbered free physical register when the free pool is not empty. It drives that register on `dst_ptag` and the previous mapping of `req_dst` on `prev_ptag`. From the next cycle, `req_dst` maps to the new register.
- R4: A request with `req_valid=1` and `req_is_move=1` writes `req_dst`, whatever the value of `req_has_dst`. It takes no register from the free pool, drives `squash=1` and `dst_ptag` equal to the source's physical register, and remaps `req_dst` to that register. Such requests are never stalled, and they may follow each other on every cycle.
- R5: Several logical registers may share one physical register. That register is not handed out again while any logical mapping still refers to it, and not while any overwritten reference to it is still unreleased.
- R6: A release (`rel_valid=1`, `rel_ptag`) removes one reference from the named register. `rel_freed` is high in the same cycle exactly when that removal brings the count to zero, and the register may then be allocated from the next cycle on.
- R7: If an accepted request adds a reference to a physical register in the same cycle that a release removes one from it, that register's count is unchanged and `rel_freed` stays low.
- R8: If an allocating request (R3) arrives while the free pool is empty, `ready` is low and no mapping or allocation changes. A release presented in that cycle is still applied.
- R9: A cycle with `req_valid=0`, or with a request that has `req_is_move=0` and `req_has_dst=0`, changes no mapping and no count. In that cycle `squash` is low, and `ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Rename request present |
| req_is_move | input | 1 | Request is a register-to-register copy |
| req_has_dst | input | 1 | Request writes a destination |
| req_src | input | 4 | Source logical register |
| req_dst | input | 4 | Destination logical register |
| ready | output | 1 | Low when an allocating request must wait |
| src_ptag | output | 5 | Physical register holding the source |
| dst_ptag | output | 5 | Physical register now named by the destination |
| prev_ptag | output | 5 | Destination's mapping before this request |
| squash | output | 1 | Request was eliminated as a copy |
| rel_valid | input | 1 | Return one reference of an overwritten mapping |
| rel_ptag | input | 5 | Physical register whose reference is returned |
| rel_freed | output | 1 | The release emptied the register's count |

## Verification
The renaming function is exercised by several kinds of input:
- Plain read-only lookups right after reset tell the identity map apart from a shifted or stale one.
- Chains of back-to-back copies, including a copy of a register onto itself, separate aliasing from allocation and show that copies never wait.
- A register aliased by four logical names and then released one reference at a time shows whether it is freed at the last release or too early.
- A copy that lands on the same cycle as a release of its source register distinguishes a correct net-zero update from a lost increment.
- A run of allocations with no releases drains the pool, to show the stall and its recovery.
- A long mixed random stream then compares every output each cycle against a queue-based model of mappings and outstanding references.

// File: rtl/mvr_pkg.sv
package mvr_pkg;

    // Kind of state update a rename request performs
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_ALLOC = 2'd1,
        OP_ALIAS = 2'd2
    } mvr_op_e;

    // Counter width able to hold 0..n
    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/mvr_map_table.sv
module mvr_map_table #(
    parameter int NUM_LOG  = 16,
    parameter int NUM_PHYS = 32,
    localparam int LW = $clog2(NUM_LOG),
    localparam int PW = $clog2(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] rd_a_idx,
    output logic [PW-1:0] rd_a_tag,
    input  logic [LW-1:0] rd_b_idx,
    output logic [PW-1:0] rd_b_tag,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_idx,
    input  logic [PW-1:0] wr_tag
);

    typedef struct packed {
        logic [NUM_LOG-1:0][PW-1:0] map;
    } map_st_t;

    function automatic map_st_t reset_state();
        map_st_t s;
        for (int i = 0; i < NUM_LOG; i++) begin
            s.map[i] = PW'(i);
        end
        return s;
    endfunction

    map_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.map[wr_idx] = wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= reset_state();
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_a_tag = st_q.map[rd_a_idx];
    assign rd_b_tag = st_q.map[rd_b_idx];

endmodule

// File: rtl/mvr_free_pick.sv
module mvr_free_pick #(
    parameter int NUM_PHYS = 32,
    localparam int PW = $clog2(NUM_PHYS)
) (
    input  logic [NUM_PHYS-1:0] free_vec,
    output logic                any_free,
    output logic [PW-1:0]       pick_tag
);

    // Lowest-numbered free register wins
    always_comb begin
        pick_tag = '0;
        for (int i = NUM_PHYS - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                pick_tag = PW'(i);
            end
        end
    end

    assign any_free = |free_vec;

endmodule

// File: rtl/mvr_refcnt.sv
module mvr_refcnt #(
    parameter int NUM_LOG  = 16,
    parameter int NUM_PHYS = 32,
    localparam int PW = $clog2(NUM_PHYS),
    localparam int CW = mvr_pkg::cnt_width(NUM_LOG + NUM_PHYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inc_en,
    input  logic [PW-1:0]       inc_tag,
    input  logic                dec_en,
    input  logic [PW-1:0]       dec_tag,
    output logic [NUM_PHYS-1:0] free_vec,
    output logic                dec_zero
);

    typedef struct packed {
        logic [NUM_PHYS-1:0][CW-1:0] cnt;
        logic [NUM_PHYS-1:0]         free;
    } rc_st_t;

    function automatic rc_st_t reset_state();
        rc_st_t s;
        for (int p = 0; p < NUM_PHYS; p++) begin
            s.cnt[p]  = (p < NUM_LOG) ? CW'(1) : CW'(0);
            s.free[p] = (p >= NUM_LOG);
        end
        return s;
    endfunction

    rc_st_t st_d, st_q;
    logic   same_tag;

    assign same_tag = inc_en && dec_en && (inc_tag == dec_tag);

    always_comb begin
        st_d = st_q;
        if (inc_en && !same_tag) begin
            st_d.cnt[inc_tag]  = st_q.cnt[inc_tag] + CW'(1);
            st_d.free[inc_tag] = 1'b0;
        end
        if (dec_en && !same_tag) begin
            st_d.cnt[dec_tag] = st_q.cnt[dec_tag] - CW'(1);
            if (st_q.cnt[dec_tag] == CW'(1)) begin
                st_d.free[dec_tag] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= reset_state();
        end else begin
            st_q <= st_d;
        end
    end

    assign free_vec = st_q.free;
    assign dec_zero = dec_en && !same_tag && (st_q.cnt[dec_tag] == CW'(1));

    // A release never targets a register without references
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |-> (st_q.cnt[dec_tag] != CW'(0)));

    // A new reference never lands on a saturated counter
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !same_tag) |-> (st_q.cnt[inc_tag] != {CW{1'b1}}));

    // Net-zero update keeps the count
    assert_net_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        same_tag |=> (st_q.cnt[$past(inc_tag)] == $past(st_q.cnt[inc_tag])));

    for (genvar p = 0; p < NUM_PHYS; p++) begin : g_free_chk
        // Free flag and zero count always agree
        assert_free_iff_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.free[p] == (st_q.cnt[p] == CW'(0)));
    end

endmodule

// File: rtl/mv_renamer.sv
module mv_renamer #(
    parameter int NUM_LOG  = 16,
    parameter int NUM_PHYS = 32,
    localparam int LW = $clog2(NUM_LOG),
    localparam int PW = $clog2(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_is_move,
    input  logic          req_has_dst,
    input  logic [LW-1:0] req_src,
    input  logic [LW-1:0] req_dst,
    output logic          ready,
    output logic [PW-1:0] src_ptag,
    output logic [PW-1:0] dst_ptag,
    output logic [PW-1:0] prev_ptag,
    output logic          squash,
    input  logic          rel_valid,
    input  logic [PW-1:0] rel_ptag,
    output logic          rel_freed
);

    import mvr_pkg::*;

    mvr_op_e             op;
    logic [NUM_PHYS-1:0] free_vec;
    logic                any_free;
    logic [PW-1:0]       pick_tag;
    logic [PW-1:0]       src_map;
    logic [PW-1:0]       dst_map;
    logic [PW-1:0]       new_tag;
    logic                stall;
    logic                write_en;

    // Classify the request
    always_comb begin
        if (!req_valid) begin
            op = OP_IDLE;
        end else if (req_is_move) begin
            op = OP_ALIAS;
        end else if (req_has_dst) begin
            op = OP_ALLOC;
        end else begin
            op = OP_IDLE;
        end
    end

    assign stall    = (op == OP_ALLOC) && !any_free;
    assign write_en = (op == OP_ALIAS) || ((op == OP_ALLOC) && any_free);
    assign new_tag  = (op == OP_ALIAS) ? src_map : pick_tag;

    mvr_map_table #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (req_src),
        .rd_a_tag (src_map),
        .rd_b_idx (req_dst),
        .rd_b_tag (dst_map),
        .wr_en    (write_en),
        .wr_idx   (req_dst),
        .wr_tag   (new_tag)
    );

    mvr_refcnt #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_en   (write_en),
        .inc_tag  (new_tag),
        .dec_en   (rel_valid),
        .dec_tag  (rel_ptag),
        .free_vec (free_vec),
        .dec_zero (rel_freed)
    );

    mvr_free_pick #(.NUM_PHYS(NUM_PHYS)) u_pick (
        .free_vec (free_vec),
        .any_free (any_free),
        .pick_tag (pick_tag)
    );

    assign ready     = !stall;
    assign src_ptag  = src_map;
    assign dst_ptag  = new_tag;
    assign prev_ptag = dst_map;
    assign squash    = (op == OP_ALIAS);

    // Allocation only hands out a register the counters call free
    assert_alloc_is_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (write_en && !squash) |-> free_vec[dst_ptag]);

    // Back-pressure only with an empty pool
    assert_stall_only_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (free_vec == '0));

    // Copies never wait
    assert_move_never_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> ready);

    // A freed register shows up in the pool one cycle later
    assert_freed_enters_pool_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rel_freed |=> free_vec[$past(rel_ptag)]);

    // A copy adding a reference to the released register keeps it alive
    assert_alias_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (squash && rel_valid && (rel_ptag == src_ptag)) |-> !rel_freed);

endmodule

// File: tb/mv_renamer_tb_top.sv
`timescale 1ns/1ps
module mv_renamer_tb_top;

    localparam int NL = 16;
    localparam int NP = 32;
    localparam int LW = 4;
    localparam int PW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_is_move = 1'b0;
    logic          req_has_dst = 1'b0;
    logic [LW-1:0] req_src = '0;
    logic [LW-1:0] req_dst = '0;
    logic          ready;
    logic [PW-1:0] src_ptag;
    logic [PW-1:0] dst_ptag;
    logic [PW-1:0] prev_ptag;
    logic          squash;
    logic          rel_valid = 1'b0;
    logic [PW-1:0] rel_ptag = '0;
    logic          rel_freed;

    int map_m[NL];
    int pend[$];
    int n_chk = 0;
    int n_fail = 0;
    bit stall_seen;

    always #4 clk = ~clk;

    mv_renamer dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_move(req_is_move),
        .req_has_dst(req_has_dst), .req_src(req_src), .req_dst(req_dst), .ready(ready),
        .src_ptag(src_ptag), .dst_ptag(dst_ptag), .prev_ptag(prev_ptag), .squash(squash),
        .rel_valid(rel_valid), .rel_ptag(rel_ptag), .rel_freed(rel_freed)
    );

    function automatic int cnt_of(input int p);
        int c = 0;
        for (int i = 0; i < NL; i++) if (map_m[i] == p) c++;
        foreach (pend[k]) if (pend[k] == p) c++;
        return c;
    endfunction

    function automatic int low_free();
        for (int p = 0; p < NP; p++) if (cnt_of(p) == 0) return p;
        return -1;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    // One cycle: drive, compare against the model mid-cycle, advance the model
    task automatic step(input string tag, input bit v, input bit mv, input bit hd,
                        input int s, input int d, input bit rv, input int ridx);
        int  rt, prev, srcp, nf, nw;
        bit  need, rdy, fire, frd;
        @(negedge clk);
        rt = rv ? pend[ridx] : 0;
        req_valid   = v;
        req_is_move = mv;
        req_has_dst = hd;
        req_src     = LW'(s);
        req_dst     = LW'(d);
        rel_valid   = rv;
        rel_ptag    = PW'(rt);
        #1;
        srcp = map_m[s];
        prev = map_m[d];
        nf   = low_free();
        need = v && !mv && hd;
        rdy  = !(need && nf < 0);
        fire = v && rdy && (mv || hd);
        nw   = mv ? srcp : nf;
        frd  = rv && (cnt_of(rt) == 1) && !(fire && nw == rt);
        if (!rdy) stall_seen = 1'b1;
        chk(tag, "ready", int'(ready), int'(rdy));
        chk(tag, "squash", int'(squash), int'(v && mv));
        if (v) chk(tag, "src_ptag", int'(src_ptag), srcp);
        if (fire) begin
            chk(tag, "dst_ptag", int'(dst_ptag), nw);
            chk(tag, "prev_ptag", int'(prev_ptag), prev);
        end
        if (rv) chk(tag, "rel_freed", int'(rel_freed), int'(frd));
        if (rv) pend.delete(ridx);
        if (fire) begin
            pend.push_back(prev);
            map_m[d] = nw;
        end
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0, 0);
    endtask

    task automatic release_all(input string tag);
        while (pend.size() > 0) step(tag, 1'b0, 1'b0, 1'b0, 0, 0, 1'b1, 0);
    endtask

    function automatic int find_pend(input int p);
        foreach (pend[k]) if (pend[k] == p) return k;
        return 0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NL; i++) map_m[i] = i;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: identity map after reset, seen through plain lookups
        for (int i = 0; i < NL; i++) step("R1", 1'b1, 1'b0, 1'b0, i, 0, 1'b0, 0);
        idle("R1");
        // R1 / R3: first allocations come from 16 upward
        step("R1", 1'b1, 1'b0, 1'b1, 0, 3, 1'b0, 0);
        step("R3", 1'b1, 1'b0, 1'b1, 3, 5, 1'b0, 0);
        step("R3", 1'b1, 1'b0, 1'b1, 3, 3, 1'b0, 0);
        step("R2", 1'b1, 1'b0, 1'b0, 3, 0, 1'b0, 0);

        // R4: back-to-back copies, including a self copy
        step("R4", 1'b1, 1'b1, 1'b1, 3, 7, 1'b0, 0);
        step("R4", 1'b1, 1'b1, 1'b0, 7, 8, 1'b0, 0);
        step("R4", 1'b1, 1'b1, 1'b1, 8, 9, 1'b0, 0);
        step("R4", 1'b1, 1'b1, 1'b1, 2, 2, 1'b0, 0);
        step("R4", 1'b1, 1'b0, 1'b0, 9, 0, 1'b0, 0);

        // R9: invalid and destination-less requests leave state alone
        step("R9", 1'b0, 1'b1, 1'b1, 4, 4, 1'b0, 0);
        step("R9", 1'b0, 1'b0, 1'b1, 1, 4, 1'b0, 0);
        step("R9", 1'b1, 1'b0, 1'b0, 5, 4, 1'b0, 0);
        step("R9", 1'b1, 1'b0, 1'b0, 4, 0, 1'b0, 0);

        // R6: return outstanding references one at a time
        release_all("R6");

        // R5: one register aliased by 3,7,8,9 is freed only at the last release
        step("R5", 1'b1, 1'b0, 1'b1, 0, 3, 1'b0, 0);
        step("R5", 1'b1, 1'b0, 1'b1, 0, 7, 1'b0, 0);
        step("R5", 1'b1, 1'b0, 1'b1, 0, 8, 1'b0, 0);
        release_all("R5");
        step("R5", 1'b1, 1'b0, 1'b1, 0, 9, 1'b0, 0);
        release_all("R5");
        step("R5", 1'b1, 1'b0, 1'b1, 0, 6, 1'b0, 0);
        release_all("R5");

        // R7: copy of a register in the same cycle its reference is returned
        step("R7", 1'b1, 1'b1, 1'b1, 1, 11, 1'b0, 0);
        step("R7", 1'b1, 1'b0, 1'b1, 0, 1, 1'b0, 0);
        step("R7", 1'b1, 1'b1, 1'b1, 11, 12, 1'b1, find_pend(map_m[11]));
        step("R7", 1'b1, 1'b0, 1'b1, 0, 11, 1'b0, 0);
        step("R7", 1'b1, 1'b0, 1'b1, 0, 12, 1'b0, 0);
        release_all("R7");

        // R8: drain the pool with no releases, then recover
        stall_seen = 1'b0;
        for (int k = 0; k < 40 && !stall_seen; k++) step("R8", 1'b1, 1'b0, 1'b1, 0, k % NL, 1'b0, 0);
        chk("R8", "stall reached", int'(stall_seen), 1);
        step("R8", 1'b1, 1'b0, 1'b1, 0, 4, 1'b0, 0);
        step("R8", 1'b1, 1'b1, 1'b1, 5, 6, 1'b0, 0);
        step("R8", 1'b1, 1'b0, 1'b1, 0, 4, 1'b1, 0);
        step("R8", 1'b1, 1'b0, 1'b1, 0, 4, 1'b0, 0);
        step("R8", 1'b1, 1'b0, 0, 4, 0, 1'b0, 0);
        release_all("R8");

        // Mixed random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            bit v, mv, hd, rv;
            int s, d, ri;
            v  = ($urandom % 4) != 0;
            mv = ($urandom % 2) != 0;
            hd = ($urandom % 4) != 0;
            s  = int'($urandom % NL);
            d  = int'($urandom % NL);
            rv = (pend.size() > 0) && ((($urandom % 3) != 0) || pend.size() > 20);
            ri = (pend.size() > 0) ? int'($urandom % pend.size()) : 0;
            step("R5", v, mv, hd, s, d, rv, ri);
        end
        release_all("R6");
        idle("R9");

        summary();
        $finish;
    end

endmodule